// File: doc/BRIEF.md
# Banked Extended-RAM Window Controller

This block lets a CPU with a 16-bit address space see one 16 KB bank of extra RAM through a fixed window. The window spans $4000 to $7FFF. Software picks the bank and the enables by writing an 8-bit control register at $D301. Reading that address returns the stored value.

On each bus cycle the block is told two things: whether the cycle belongs to the CPU or to the video DMA fetcher, and which address is being used. When the address falls inside the window and the active agent's enable is on, the block asserts the extended-RAM select. It also tells the main-RAM decoder to stay off the bus, and it forms the extended-RAM address from the bank number and the low 14 address bits. Both agents always use the same bank field, so they can never reach two different extended banks in the same configuration.

A build-time parameter picks the register layout:
- **Split layout**: four banks, with separate active-low enables for the CPU and for video.
- **Shared layout**: a 4-bit selector gathered from scattered bits, with one shared enable. Twelve of its codes reach extended banks and four leave the window on main memory.

Top module: `bwin_ctrl`

## Requirements
- R1: A CPU write cycle at $D301 stores the data byte in the control register. `reg_rdata` always shows the stored byte. `reg_hit` is high during a CPU cycle at $D301.
- R2: After reset the register holds $FF, and neither agent gets the window.
- R3: `xram_sel` is only ever asserted for a valid cycle whose address lies in $4000..$7FFF. $3FFF and $8000 never select.
- R4: When selected, `xram_addr` equals {bank, bus_addr[13:0]}. In the split layout the bank is register bits [3:2].
- R5: In the split layout, register bit 4 low opens the window to CPU cycles only.
- R6: In the split layout, register bit 5 low opens the window to video cycles only.
- R7: In the shared layout the selector is {bit6, bit5, bit3, bit2}. With the default lookup, selector codes 12..15 map the window to main memory (no select). Codes 0..11 select extended bank 0..11, and this bank appears in the top 4 bits of `xram_addr`.
- R8: In the shared layout, register bit 4 low opens the window to both agents, and bit 5 acts only as a selector bit.
- R9: Register bits 0, 1 and 7 are stored and read back but do not change banking.
- R10: A register write is visible only from the next cycle. During the write cycle `reg_rdata` still shows the old value.
- R11: Video cycles never write the register and never raise `reg_hit`.
- R12: `main_inhibit` is high exactly when `xram_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_video | input | 1 | 1 = video DMA cycle, 0 = CPU cycle |
| bus_we | input | 1 | CPU write strobe |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_wdata | input | 8 | CPU write data |
| reg_hit | output | 1 | CPU cycle addresses the control register |
| reg_rdata | output | 8 | Stored control byte |
| xram_addr | output | BANK_W+14 (16 split, 18 shared) | Extended-RAM address {bank, offset} |
| xram_sel | output | 1 | Extended-RAM chip select |
| main_inhibit | output | 1 | Main-RAM decoder must not respond |

## Verification
A split-layout instance and a shared-layout instance are driven from the same bus with a vector table. Each row writes a control byte and then makes one access. The rows are chosen to tell several cases apart:
- a CPU enable from a video enable;
- bit 5 as an enable from bit 5 as a selector bit;
- main-memory selector codes from extended ones;
- window edges from addresses just outside them.

Directed cases cover the reset value, the old-value-during-write timing, video writes and reads of the register, and bytes that differ only in the non-banking bits.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

    typedef enum logic {
        LAYOUT_SPLIT4   = 1'b0,
        LAYOUT_SHARED12 = 1'b1
    } layout_e;

    localparam int CTL_W = 8;

    // bit positions decoded by the bank map
    localparam int BIT_BANK_LO = 2;
    localparam int BIT_BANK_HI = 3;
    localparam int BIT_CPU_EN  = 4;
    localparam int BIT_VID_EN  = 5;
    localparam int BIT_SEL_TOP = 6;

    localparam logic [CTL_W-1:0] CTL_RESET = 8'hFF;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;

    typedef struct packed {
        logic reg_hit;
        logic wr_en;
        logic agent_open;
        logic xsel;
    } dec_t;

    // Number of extended (non-main) codes below 'code': compacts the
    // twelve extended codes onto bank numbers 0..11.
    function automatic logic [3:0] code_rank(input logic [15:0] main_mask,
                                             input logic [3:0]  code);
        logic [3:0] rank;
        rank = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if ((i < int'(code)) && !main_mask[i]) begin
                rank = rank + 4'd1;
            end
        end
        return rank;
    endfunction

endpackage

// File: rtl/bwin_ctl_reg.sv
module bwin_ctl_reg
    import bwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q
);

    ctl_state_t st_d;
    ctl_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctl: CTL_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;

endmodule

// File: rtl/bwin_addr_match.sv
module bwin_addr_match #(
    parameter int              ADDR_W     = 16,
    parameter int              WIN_ADDR_W = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hD301
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic              at_reg
);

    localparam int TAG_W = ADDR_W - WIN_ADDR_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_ADDR_W];

    always_comb begin
        in_window = (addr[ADDR_W-1:WIN_ADDR_W] == WIN_TAG);
        at_reg    = (addr == REG_ADDR);
    end

endmodule

// File: rtl/bwin_bank_map.sv
module bwin_bank_map
    import bwin_pkg::*;
#(
    parameter layout_e     LAYOUT    = LAYOUT_SPLIT4,
    parameter int          BANK_W    = 2,
    parameter logic [15:0] MAIN_MASK = 16'hF000
) (
    input  logic [CTL_W-1:0]  ctl,
    output logic [BANK_W-1:0] bank,
    output logic              cpu_open,
    output logic              vid_open
);

    generate
        if (LAYOUT == LAYOUT_SPLIT4) begin : g_split
            logic unused_ctl;
            assign unused_ctl = ^{ctl[7:6], ctl[1:0]};

            always_comb begin
                bank     = ctl[BIT_BANK_HI:BIT_BANK_LO];
                cpu_open = ~ctl[BIT_CPU_EN];
                vid_open = ~ctl[BIT_VID_EN];
            end
        end else begin : g_shared
            logic [3:0] code;
            logic [3:0] rank;
            logic       is_ext;
            logic       open;
            logic       unused_ctl;
            assign unused_ctl = ^{ctl[7], ctl[1:0]};

            always_comb begin
                code     = {ctl[BIT_SEL_TOP], ctl[BIT_VID_EN],
                            ctl[BIT_BANK_HI], ctl[BIT_BANK_LO]};
                rank     = code_rank(MAIN_MASK, code);
                is_ext   = ~MAIN_MASK[code];
                open     = ~ctl[BIT_CPU_EN] & is_ext;
                bank     = rank[BANK_W-1:0];
                cpu_open = open;
                vid_open = open;
            end
        end
    endgenerate

endmodule

// File: rtl/bwin_ctrl.sv
module bwin_ctrl
    import bwin_pkg::*;
#(
    parameter layout_e           LAYOUT     = LAYOUT_SPLIT4,
    parameter int                ADDR_W     = 16,
    parameter int                WIN_ADDR_W = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 16'h4000,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 16'hD301,
    parameter logic [15:0]       MAIN_MASK  = 16'hF000,
    localparam int               BANK_W     = (LAYOUT == LAYOUT_SHARED12) ? 4 : 2,
    localparam int               XA_W       = BANK_W + WIN_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_video,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  bus_wdata,
    output logic              reg_hit,
    output logic [CTL_W-1:0]  reg_rdata,
    output logic [XA_W-1:0]   xram_addr,
    output logic              xram_sel,
    output logic              main_inhibit
);

    logic              in_window;
    logic              at_reg;
    logic [CTL_W-1:0]  ctl_q;
    logic [BANK_W-1:0] bank;
    logic              cpu_open;
    logic              vid_open;
    dec_t              dec;

    bwin_addr_match #(
        .ADDR_W    (ADDR_W),
        .WIN_ADDR_W(WIN_ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .REG_ADDR  (REG_ADDR)
    ) u_match (
        .addr     (bus_addr),
        .in_window(in_window),
        .at_reg   (at_reg)
    );

    bwin_ctl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (dec.wr_en),
        .wr_data(bus_wdata),
        .ctl_q  (ctl_q)
    );

    bwin_bank_map #(
        .LAYOUT   (LAYOUT),
        .BANK_W   (BANK_W),
        .MAIN_MASK(MAIN_MASK)
    ) u_map (
        .ctl     (ctl_q),
        .bank    (bank),
        .cpu_open(cpu_open),
        .vid_open(vid_open)
    );

    always_comb begin
        dec.reg_hit    = bus_valid & ~bus_video & at_reg;
        dec.wr_en      = dec.reg_hit & bus_we;
        dec.agent_open = bus_video ? vid_open : cpu_open;
        dec.xsel       = bus_valid & in_window & dec.agent_open;
    end

    assign reg_hit      = dec.reg_hit;
    assign reg_rdata    = ctl_q;
    assign xram_addr    = {bank, bus_addr[WIN_ADDR_W-1:0]};
    assign xram_sel     = dec.xsel;
    assign main_inhibit = dec.xsel;

endmodule

// File: rtl/bwin_ctrl_chk.sv
module bwin_ctrl_chk #(
    parameter int                ADDR_W     = 16,
    parameter int                WIN_ADDR_W = 14,
    parameter int                XA_W       = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 16'h4000,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 16'hD301
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_video,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              reg_hit,
    input logic [7:0]        reg_rdata,
    input logic [XA_W-1:0]   xram_addr,
    input logic              xram_sel,
    input logic              main_inhibit
);

    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(1 << WIN_ADDR_W) - 1'b1;

    logic fresh_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fresh_q <= 1'b1;
        else        fresh_q <= 1'b0;
    end

    assert_reset_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_q |-> (reg_rdata == 8'hFF));

    assert_sel_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xram_sel |-> (bus_valid && ({1'b0, bus_addr} >= WIN_LO) && ({1'b0, bus_addr} <= WIN_HI)));

    assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xram_sel |-> (xram_addr[WIN_ADDR_W-1:0] == bus_addr[WIN_ADDR_W-1:0]));

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_video && bus_we && (bus_addr == REG_ADDR))
        |=> (reg_rdata == $past(bus_wdata)));

    assert_video_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_video) |=> $stable(reg_rdata));

    assert_video_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_video |-> !reg_hit);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!main_inhibit && !xram_sel));

    assert_inhibit_pairs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        main_inhibit |-> xram_sel);

endmodule

bind bwin_ctrl bwin_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_ADDR_W(WIN_ADDR_W),
    .XA_W      (XA_W),
    .WIN_BASE  (WIN_BASE),
    .REG_ADDR  (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_video   (bus_video),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .reg_hit     (reg_hit),
    .reg_rdata   (reg_rdata),
    .xram_addr   (xram_addr),
    .xram_sel    (xram_sel),
    .main_inhibit(main_inhibit)
);

// File: tb/bwin_ctrl_tb.sv
module bwin_ctrl_tb;
    import bwin_pkg::*;

    localparam logic [15:0] REG_A = 16'hD301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_video = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;

    logic        hit0, hit1, sel0, sel1, inh0, inh1;
    logic [7:0]  rd0, rd1;
    logic [15:0] xa0;
    logic [17:0] xa1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bwin_ctrl #(.LAYOUT(LAYOUT_SPLIT4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_video(bus_video),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .reg_hit(hit0), .reg_rdata(rd0), .xram_addr(xa0),
        .xram_sel(sel0), .main_inhibit(inh0));

    bwin_ctrl #(.LAYOUT(LAYOUT_SHARED12)) u_dut12 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_video(bus_video),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .reg_hit(hit1), .reg_rdata(rd1), .xram_addr(xa1),
        .xram_sel(sel1), .main_inhibit(inh1));

    // {ctl[7:0], video, addr[15:0], split sel, split bank[1:0], shared sel, shared bank[3:0]}
    localparam logic [32:0] VEC [0:10] = '{
        {8'hE3, 1'b0, 16'h4000, 1'b1, 2'd0, 1'b0, 4'd0},
        {8'hA7, 1'b0, 16'h7FFF, 1'b1, 2'd1, 1'b1, 4'd5},
        {8'hA7, 1'b1, 16'h5000, 1'b0, 2'd0, 1'b1, 4'd5},
        {8'hCF, 1'b1, 16'h6123, 1'b1, 2'd3, 1'b1, 4'd11},
        {8'hCF, 1'b0, 16'h8000, 1'b0, 2'd0, 1'b0, 4'd0},
        {8'hCF, 1'b0, 16'h3FFF, 1'b0, 2'd0, 1'b0, 4'd0},
        {8'hDB, 1'b1, 16'h4ABC, 1'b1, 2'd2, 1'b0, 4'd0},
        {8'hDB, 1'b0, 16'h4ABC, 1'b0, 2'd0, 1'b0, 4'd0},
        {8'h08, 1'b0, 16'h4001, 1'b1, 2'd2, 1'b1, 4'd2},
        {8'h48, 1'b0, 16'h7000, 1'b1, 2'd2, 1'b1, 4'd10},
        {8'h64, 1'b0, 16'h4000, 1'b1, 2'd1, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_video = 1'b0; bus_we = 1'b1;
        bus_addr = REG_A; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic access(input logic vid, input logic [15:0] a);
        bus_valid = 1'b1; bus_video = vid; bus_we = 1'b0; bus_addr = a;
        #2;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, window closed to both agents
        #2;
        chk("R2 split reset value", rd0, 8'hFF);
        chk("R2 shared reset value", rd1, 8'hFF);
        @(negedge clk); access(1'b0, 16'h4000);
        chk("R2 cpu closed after reset", {sel0, sel1}, 2'b00);
        @(negedge clk); access(1'b1, 16'h7FFF);
        chk("R2 video closed after reset", {sel0, sel1}, 2'b00);

        // R10: old value during the write cycle, new value right after
        @(negedge clk);
        bus_valid = 1'b1; bus_video = 1'b0; bus_we = 1'b1;
        bus_addr = REG_A; bus_wdata = 8'h00;
        #2;
        chk("R10 old value during write", {rd0, rd1}, 16'hFFFF);
        @(negedge clk); access(1'b1, 16'h4000);
        chk("R10 new value next cycle", {rd0, rd1}, 16'h0000);
        chk("R10 window opens next cycle", {sel0, sel1}, 2'b11);

        // table of write-then-access vectors
        for (int i = 0; i < 11; i++) begin
            logic [32:0] v;
            v = VEC[i];
            do_write(v[32:25]);
            #2;
            chk("R1 readback split", rd0, v[32:25]);
            chk("R1 readback shared", rd1, v[32:25]);
            access(v[24], v[23:8]);
            chk("R3 R5 R6 split select", sel0, v[7]);
            chk("R3 R7 R8 shared select", sel1, v[4]);
            chk("R12 split inhibit", inh0, sel0);
            chk("R12 shared inhibit", inh1, sel1);
            if (v[7]) chk("R4 split address", xa0, {v[6:5], v[21:8]});
            if (v[4]) chk("R7 shared address", xa1, {v[3:0], v[21:8]});
        end

        // R11: video write to the register is ignored and no hit
        @(negedge clk);
        bus_valid = 1'b1; bus_video = 1'b1; bus_we = 1'b1;
        bus_addr = REG_A; bus_wdata = 8'h00;
        #2;
        chk("R11 no hit on video", {hit0, hit1}, 2'b00);
        @(negedge clk); access(1'b0, 16'h4000);
        chk("R11 register kept", {rd0, rd1}, 16'h6464);

        // R1: CPU read at the register raises reg_hit, no change
        @(negedge clk); access(1'b0, REG_A);
        chk("R1 hit on cpu read", {hit0, hit1}, 2'b11);
        @(negedge clk); access(1'b0, 16'h4000);
        chk("R1 read does not write", {rd0, rd1}, 16'h6464);

        // R9: bits 0,1,7 differ, banking unchanged
        do_write(8'h08);
        do_write(8'h8B);
        #2;
        chk("R9 readback of system bits", {rd0, rd1}, 16'h8B8B);
        access(1'b0, 16'h4001);
        chk("R9 split select", sel0, 1'b1);
        chk("R9 split address", xa0, {2'd2, 14'h0001});
        chk("R9 shared select", sel1, 1'b1);
        chk("R9 shared address", xa1, {4'd2, 14'h0001});

        // R3: idle bus selects nothing
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 16'h4000;
        #2;
        chk("R3 idle no select", {sel0, sel1, inh0, inh1}, 4'b0000);

        finish_run();
    end

endmodule